// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences a small processor subsystem between its running state and three low-power states: a light sleep, a deep sleep and a backup state. The processor signals that it wants to stop with a single-cycle wait-for-interrupt or wait-for-event pulse. The sequencer then uses a stored power-mode field and a deep-sleep select bit to choose the target state. In each state it drives clock-gate enables for the core, the system fabric, the watchdog and the real-time clock, plus an enable for the system oscillator.

The light sleep stops only the core clock. Any interrupt, watchdog event or RTC event ends it. The deep sleep and backup states stop the core, system and watchdog clocks. The RTC clock and the oscillator keep running only if they were configured to do so at entry. Only a GPIO interrupt whose wake enable is set, or an RTC wakeup whose enable is set, ends these two states. A wakeup first turns every clock back on for one cycle and marks that cycle with a done pulse. The block is back in the running state one cycle later.

Top module: `lp_seq_ctrl`

## Requirements
- R1: Reset (rst_ni low, asynchronous) forces the running state. In that state mode_o = 0, all five enables (core, sys, wdt, rtc, osc) are 1, and wake_done_o = 0. The power-mode field resets to 0.
- R2: A wfi_i or wfe_i pulse in the running state, with the power-mode field at 0 and deep_sel_i = 0, enters light sleep on the next cycle. Light sleep reports mode_o = 1 with core_clk_en_o = 0 and the sys, wdt, rtc and osc enables at 1.
- R3: With the power-mode field at 0 and deep_sel_i = 1, the pulse enters deep sleep (mode_o = 2). The core, sys and wdt enables go to 0. rtc_clk_en_o equals rtc_run_i and osc_en_o equals osc_keep_i, both sampled in the entry cycle.
- R4: With a nonzero power-mode field, the pulse enters backup (mode_o = 3) whatever deep_sel_i is. The core, sys, wdt and osc enables go to 0, and rtc_clk_en_o equals rtc_run_i sampled at entry.
- R5: In light sleep, any bit of irq_i, wdt_irq_i, rtc_wake_i (whatever its enable) or any bit of gpio_irq_i (whatever its enable) starts a wakeup.
- R6: In deep sleep and backup, a wakeup starts only on gpio_irq_i & gpio_wake_en_i being nonzero or on rtc_wake_i & rtc_wake_en_i. Other events leave mode_o and all enables unchanged.
- R7: In the cycle after a qualifying wake event is sampled, all five enables are 1, wake_done_o = 1 and mode_o still shows the state being left. One cycle later mode_o = 0 and wake_done_o = 0.
- R8: wfi_i and wfe_i have no effect outside the running state, including the wakeup cycle.
- R9: If a wake event that would qualify for the chosen target state is present in the entry cycle, entry is aborted. The block stays in the running state with no wake_done_o pulse. An event that does not qualify for that target does not abort entry.
- R10: The power-mode field loads cfg_wdata_i only in a cycle with cfg_we_i = 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wfi_i | input | 1 | Wait-for-interrupt pulse from the core |
| wfe_i | input | 1 | Wait-for-event pulse from the core |
| deep_sel_i | input | 1 | Deep-sleep select bit |
| cfg_we_i | input | 1 | Write strobe for the power-mode field |
| cfg_wdata_i | input | PM_W | Power-mode field write data |
| rtc_run_i | input | 1 | Keep RTC clock running in deep states |
| osc_keep_i | input | 1 | Keep oscillator running in deep sleep |
| irq_i | input | N_IRQ | Peripheral interrupt lines |
| wdt_irq_i | input | 1 | Watchdog interrupt |
| rtc_wake_i | input | 1 | RTC wakeup event |
| rtc_wake_en_i | input | 1 | RTC wake enable for deep states |
| gpio_irq_i | input | N_GPIO | GPIO external interrupt lines |
| gpio_wake_en_i | input | N_GPIO | Per-line GPIO wake enables |
| core_clk_en_o | output | 1 | Core clock gate enable |
| sys_clk_en_o | output | 1 | System clock gate enable |
| wdt_clk_en_o | output | 1 | Watchdog clock gate enable |
| rtc_clk_en_o | output | 1 | RTC clock gate enable |
| osc_en_o | output | 1 | System oscillator enable |
| mode_o | output | 2 | Current mode: 0 run, 1 sleep, 2 deep sleep, 3 backup |
| wake_done_o | output | 1 | One-cycle pulse marking the wakeup cycle |

## Verification
The bench targets the difference in wake filtering between states. It applies ordinary interrupts, watchdog events and disabled GPIO or RTC events in deep sleep and backup. A design that used the light-sleep filter there would leave those states when it should not. It raises a wake event in the same cycle as the entry pulse, once with an event that qualifies for the target and once with one that does not. A design with no abort, or with an abort based on the wrong filter, would either enter a state it cannot wake from or refuse a valid entry. It also sends entry pulses during a low-power state and during the wakeup cycle. A design that accepts them would re-enter or skip the done pulse. It selects backup with the deep bit both clear and set, where getting the precedence wrong shows up as mode 2 with the oscillator left on.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_DEEP   = 3'd2,
    ST_BACKUP = 3'd3,
    ST_WAKE   = 3'd4
  } lp_state_e;

  typedef struct packed {
    logic core;
    logic sys;
    logic wdt;
    logic rtc;
    logic osc;
  } clk_en_t;

  localparam clk_en_t CLK_ALL_ON = '{core: 1'b1, sys: 1'b1, wdt: 1'b1, rtc: 1'b1, osc: 1'b1};

endpackage

// File: rtl/lp_wake_qual.sv
module lp_wake_qual #(
  parameter int N_IRQ  = 8,
  parameter int N_GPIO = 4
) (
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              wdt_irq_i,
  input  logic              rtc_wake_i,
  input  logic              rtc_wake_en_i,
  input  logic [N_GPIO-1:0] gpio_irq_i,
  input  logic [N_GPIO-1:0] gpio_wake_en_i,
  output logic              wake_light_o,
  output logic              wake_deep_o
);

  logic [N_GPIO-1:0] gpio_armed;

  for (genvar g = 0; g < N_GPIO; g++) begin : g_gpio
    assign gpio_armed[g] = gpio_irq_i[g] & gpio_wake_en_i[g];
  end

  // light sleep: any source, enables ignored
  assign wake_light_o = (|irq_i) | wdt_irq_i | rtc_wake_i | (|gpio_irq_i);
  // deep states: only enabled gpio or enabled rtc
  assign wake_deep_o  = (|gpio_armed) | (rtc_wake_i & rtc_wake_en_i);

endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
  import lp_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      entry_i,
  input  logic      pm_nz_i,
  input  logic      deep_sel_i,
  input  logic      wake_light_i,
  input  logic      wake_deep_i,
  input  logic      rtc_run_i,
  input  logic      osc_keep_i,
  output lp_state_e state_o,
  output logic [1:0] last_mode_o,
  output logic      rtc_keep_o,
  output logic      osc_keep_o
);

  lp_state_e  state_q, state_d, tgt;
  logic [1:0] mode_q, mode_d;
  logic       rtc_q, rtc_d, osc_q, osc_d, abort;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    rtc_d   = rtc_q;
    osc_d   = osc_q;
    tgt     = pm_nz_i ? ST_BACKUP : (deep_sel_i ? ST_DEEP : ST_SLEEP);
    abort   = (tgt == ST_SLEEP) ? wake_light_i : wake_deep_i;
    case (state_q)
      ST_ACTIVE: if (entry_i && !abort) begin
        state_d = tgt;
        mode_d  = 2'(tgt);
        rtc_d   = rtc_run_i;
        osc_d   = osc_keep_i;
      end
      ST_SLEEP:  if (wake_light_i) state_d = ST_WAKE;
      ST_DEEP,
      ST_BACKUP: if (wake_deep_i) state_d = ST_WAKE;
      ST_WAKE:   state_d = ST_ACTIVE;
      default:   state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      mode_q  <= 2'd0;
      rtc_q   <= 1'b1;
      osc_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      rtc_q   <= rtc_d;
      osc_q   <= osc_d;
    end
  end

  assign state_o     = state_q;
  assign last_mode_o = mode_q;
  assign rtc_keep_o  = rtc_q;
  assign osc_keep_o  = osc_q;

  a_r6_deep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_DEEP || state_q == ST_BACKUP) && !wake_deep_i) |=> $stable(state_q));

  a_r7_lp_exits_via_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP || state_q == ST_DEEP || state_q == ST_BACKUP) |=> state_q != ST_ACTIVE);

  a_r8_wake_ignores_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |=> state_q == ST_ACTIVE);

  a_r9_abort_stays_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && entry_i &&
     ((pm_nz_i || deep_sel_i) ? wake_deep_i : wake_light_i)) |=> state_q == ST_ACTIVE);

endmodule

// File: rtl/lp_clk_dec.sv
module lp_clk_dec
  import lp_seq_pkg::*;
(
  input  lp_state_e  state_i,
  input  logic [1:0] last_mode_i,
  input  logic       rtc_keep_i,
  input  logic       osc_keep_i,
  output clk_en_t    en_o,
  output logic [1:0] mode_o,
  output logic       wake_done_o
);

  always_comb begin
    en_o   = CLK_ALL_ON;
    mode_o = 2'd0;
    case (state_i)
      ST_SLEEP: begin
        en_o.core = 1'b0;
        mode_o    = 2'd1;
      end
      ST_DEEP: begin
        en_o   = '{core: 1'b0, sys: 1'b0, wdt: 1'b0, rtc: rtc_keep_i, osc: osc_keep_i};
        mode_o = 2'd2;
      end
      ST_BACKUP: begin
        en_o   = '{core: 1'b0, sys: 1'b0, wdt: 1'b0, rtc: rtc_keep_i, osc: 1'b0};
        mode_o = 2'd3;
      end
      ST_WAKE:  mode_o = last_mode_i;  // clocks back on, mode still shown
      default:  mode_o = 2'd0;
    endcase
  end

  assign wake_done_o = (state_i == ST_WAKE);

endmodule

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl
  import lp_seq_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int N_GPIO = 4,
  parameter int PM_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              deep_sel_i,
  input  logic              cfg_we_i,
  input  logic [PM_W-1:0]   cfg_wdata_i,
  input  logic              rtc_run_i,
  input  logic              osc_keep_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              wdt_irq_i,
  input  logic              rtc_wake_i,
  input  logic              rtc_wake_en_i,
  input  logic [N_GPIO-1:0] gpio_irq_i,
  input  logic [N_GPIO-1:0] gpio_wake_en_i,
  output logic              core_clk_en_o,
  output logic              sys_clk_en_o,
  output logic              wdt_clk_en_o,
  output logic              rtc_clk_en_o,
  output logic              osc_en_o,
  output logic [1:0]        mode_o,
  output logic              wake_done_o
);

  logic [PM_W-1:0] pm_q;
  logic            wake_light, wake_deep, rtc_keep, osc_keep;
  logic [1:0]      last_mode;
  lp_state_e       state;
  clk_en_t         en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pm_q <= '0;
    else if (cfg_we_i) pm_q <= cfg_wdata_i;
  end

  lp_wake_qual #(.N_IRQ(N_IRQ), .N_GPIO(N_GPIO)) u_qual (
    .irq_i          (irq_i),
    .wdt_irq_i      (wdt_irq_i),
    .rtc_wake_i     (rtc_wake_i),
    .rtc_wake_en_i  (rtc_wake_en_i),
    .gpio_irq_i     (gpio_irq_i),
    .gpio_wake_en_i (gpio_wake_en_i),
    .wake_light_o   (wake_light),
    .wake_deep_o    (wake_deep)
  );

  lp_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .entry_i      (wfi_i | wfe_i),
    .pm_nz_i      (|pm_q),
    .deep_sel_i   (deep_sel_i),
    .wake_light_i (wake_light),
    .wake_deep_i  (wake_deep),
    .rtc_run_i    (rtc_run_i),
    .osc_keep_i   (osc_keep_i),
    .state_o      (state),
    .last_mode_o  (last_mode),
    .rtc_keep_o   (rtc_keep),
    .osc_keep_o   (osc_keep)
  );

  lp_clk_dec u_dec (
    .state_i     (state),
    .last_mode_i (last_mode),
    .rtc_keep_i  (rtc_keep),
    .osc_keep_i  (osc_keep),
    .en_o        (en),
    .mode_o      (mode_o),
    .wake_done_o (wake_done_o)
  );

  assign core_clk_en_o = en.core;
  assign sys_clk_en_o  = en.sys;
  assign wdt_clk_en_o  = en.wdt;
  assign rtc_clk_en_o  = en.rtc;
  assign osc_en_o      = en.osc;

  a_r10_pm_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(pm_q));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> (!wake_done_o && mode_o == 2'd0 && core_clk_en_o));

  a_r4_backup_osc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && !wake_done_o) |-> (!osc_en_o && !sys_clk_en_o));

  a_r2_core_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0 && !wake_done_o) |-> !core_clk_en_o);

endmodule

// File: tb/lp_seq_ctrl_bench.sv
module lp_seq_ctrl_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wfi_i = 0, wfe_i = 0, deep_sel_i = 0, cfg_we_i = 0;
  logic [1:0] cfg_wdata_i = '0;
  logic       rtc_run_i = 0, osc_keep_i = 0;
  logic [7:0] irq_i = '0;
  logic       wdt_irq_i = 0, rtc_wake_i = 0, rtc_wake_en_i = 0;
  logic [3:0] gpio_irq_i = '0, gpio_wake_en_i = '0;
  logic       core_clk_en_o, sys_clk_en_o, wdt_clk_en_o, rtc_clk_en_o, osc_en_o, wake_done_o;
  logic [1:0] mode_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  lp_seq_ctrl u_lp_seq_ctrl (.*);

  // {pm[1:0], deep, rtc_run, osc_keep, use_wfe, exp_mode[1:0], core,sys,wdt,rtc,osc,done}
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 6'b011110},
    {2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 6'b011110},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 6'b000000},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 6'b000110},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 6'b000100},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 6'b000000},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 6'b000100},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 6'b000100}
  };

  localparam logic [7:0] OBS_ACTIVE = {2'd0, 6'b111110};

  function automatic logic [7:0] obs();
    return {mode_o, core_clk_en_o, sys_clk_en_o, wdt_clk_en_o, rtc_clk_en_o, osc_en_o, wake_done_o};
  endfunction

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_pm(input logic [1:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v; tick(); cfg_we_i = 1'b0;
  endtask

  task automatic go_low(input logic deep);
    deep_sel_i = deep; wfi_i = 1'b1; tick(); wfi_i = 1'b0;
  endtask

  task automatic gpio_wake(input logic [1:0] m);
    gpio_wake_en_i = 4'b0001; gpio_irq_i = 4'b0001; tick(); gpio_irq_i = '0; gpio_wake_en_i = '0;
    chk("R7 wake cycle", obs(), {m, 6'b111111});
    tick();
    chk("R7 back to run", obs(), OBS_ACTIVE);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick();
    chk("R1 in reset", obs(), OBS_ACTIVE);
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 after reset", obs(), OBS_ACTIVE);

    // table walk: R2 / R3 / R4 entries, R7 wakeups
    for (int i = 0; i < 8; i++) begin
      logic [13:0] v;
      v = VEC[i];
      set_pm(v[13:12]);
      deep_sel_i = v[11]; rtc_run_i = v[10]; osc_keep_i = v[9];
      if (v[8]) wfe_i = 1'b1; else wfi_i = 1'b1;
      tick();
      wfi_i = 1'b0; wfe_i = 1'b0;
      chk(v[7:6] == 2'd1 ? "R2 sleep entry" : (v[7:6] == 2'd2 ? "R3 deep entry" : "R4 backup entry"),
          obs(), v[7:0]);
      gpio_wake(v[7:6]);
    end

    // R10: write without strobe is ignored
    set_pm(2'd0);
    cfg_wdata_i = 2'd3; tick();
    go_low(1'b0);
    chk("R10 no-strobe write ignored", obs(), {2'd1, 6'b011110});

    // R5: sleep wakes on a peripheral irq
    irq_i = 8'h20; tick(); irq_i = '0;
    chk("R5 irq wakes sleep", obs(), {2'd1, 6'b111111});
    tick();
    chk("R5 run after irq wake", obs(), OBS_ACTIVE);

    // R8: entry pulse inside sleep and inside wake cycle
    go_low(1'b0);
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    chk("R8 pulse in sleep ignored", obs(), {2'd1, 6'b011110});
    wdt_irq_i = 1'b1; tick(); wdt_irq_i = 1'b0;
    chk("R5 watchdog wakes sleep", obs(), {2'd1, 6'b111111});
    wfi_i = 1'b1; tick(); wfi_i = 1'b0;
    chk("R8 pulse in wake cycle ignored", obs(), OBS_ACTIVE);
    tick();
    chk("R8 still running", obs(), OBS_ACTIVE);

    // R5: rtc wake with enable clear still wakes sleep
    go_low(1'b0);
    rtc_wake_en_i = 1'b0; rtc_wake_i = 1'b1; tick(); rtc_wake_i = 1'b0;
    chk("R5 rtc wakes sleep", obs(), {2'd1, 6'b111111});
    tick();

    // R6: deep sleep filters
    rtc_run_i = 1'b1; osc_keep_i = 1'b1;
    go_low(1'b1);
    chk("R3 deep entry kept clocks", obs(), {2'd2, 6'b000110});
    irq_i = 8'hFF; wdt_irq_i = 1'b1; rtc_wake_i = 1'b1; gpio_irq_i = 4'hF;
    tick();
    irq_i = '0; wdt_irq_i = 1'b0; rtc_wake_i = 1'b0; gpio_irq_i = '0;
    chk("R6 deep ignores unqualified", obs(), {2'd2, 6'b000110});
    gpio_wake_en_i = 4'b0001; gpio_irq_i = 4'b1110; tick(); gpio_irq_i = '0; gpio_wake_en_i = '0;
    chk("R6 deep ignores disabled gpio", obs(), {2'd2, 6'b000110});
    rtc_wake_en_i = 1'b1; rtc_wake_i = 1'b1; tick(); rtc_wake_i = 1'b0; rtc_wake_en_i = 1'b0;
    chk("R6 enabled rtc wakes deep", obs(), {2'd2, 6'b111111});
    tick();
    chk("R7 run after deep", obs(), OBS_ACTIVE);

    // R6: backup filters, R4 precedence
    set_pm(2'd1);
    go_low(1'b1);
    chk("R4 backup over deep bit", obs(), {2'd3, 6'b000100});
    irq_i = 8'h01; wdt_irq_i = 1'b1; tick(); irq_i = '0; wdt_irq_i = 1'b0;
    chk("R6 backup ignores irq", obs(), {2'd3, 6'b000100});
    gpio_wake_en_i = 4'b0100; gpio_irq_i = 4'b0100; tick(); gpio_irq_i = '0; gpio_wake_en_i = '0;
    chk("R6 enabled gpio wakes backup", obs(), {2'd3, 6'b111111});
    tick();
    set_pm(2'd0);

    // R9: abort on coincident qualified event
    deep_sel_i = 1'b1; wfi_i = 1'b1; gpio_wake_en_i = 4'b0001; gpio_irq_i = 4'b0001;
    tick();
    wfi_i = 1'b0; gpio_irq_i = '0; gpio_wake_en_i = '0;
    chk("R9 deep entry aborted", obs(), OBS_ACTIVE);
    tick();
    chk("R9 no done after abort", obs(), OBS_ACTIVE);
    deep_sel_i = 1'b0; wfe_i = 1'b1; irq_i = 8'h01; tick(); wfe_i = 1'b0; irq_i = '0;
    chk("R9 sleep entry aborted", obs(), OBS_ACTIVE);
    deep_sel_i = 1'b1; wfi_i = 1'b1; irq_i = 8'h04; tick(); wfi_i = 1'b0; irq_i = '0;
    chk("R9 unqualified event no abort", obs(), {2'd2, 6'b000110});

    // R1: async reset from deep sleep
    #3 rst_ni = 1'b0;
    #2 chk("R1 async reset in deep", obs(), OBS_ACTIVE);
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 run after reset", obs(), OBS_ACTIVE);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule